// File: doc/BRIEF.md
# Machine Status Word Coprocessor Trap Unit

This unit keeps the processor's 16-bit machine status word and decides, for every instruction that touches the numeric coprocessor, whether that instruction must be stopped with the coprocessor-not-present trap (vector 7). Only the four low bits carry meaning. Bit 0 enables protected mode. Bit 1 asks that wait-type instructions be monitored. Bit 2 asks that escape opcodes be emulated in software. Bit 3 records that a hardware task switch has happened since the coprocessor context was last claimed. The upper twelve bits are reserved and held at their reset value.

The decode stage presents an instruction class each cycle. It can also present a request to load the word, which is privileged, and a request to clear the task-switched flag, which is also privileged, together with the current privilege level and a real-mode flag. The task-switch logic pulses a single input when it changes tasks. The word is always visible on a read port, because storing it is allowed at every privilege level. The trap and privilege-fault outputs are combinational for the current cycle, so the exception logic can act on them in the same cycle. Register updates take effect at the next clock edge.

Top module: `msw_cop_trap`

## Requirements
- R1: After reset the whole word is zero (the reserved field takes parameter `RSVD_INIT`, default 0), and `nm_trap`, `trap_vec` and `priv_fault` are all 0.
- R2: A permitted load copies `ld_data[1]` into the monitor bit (word bit 1) and `ld_data[2]` into the emulate bit (word bit 2), visible on `msw` one cycle after the request.
- R3: A load is permitted only when `real_mode` is 1 or `cpl` is 0. Otherwise `priv_fault` is 1 in the same cycle and the word does not change.
- R4: The protected-mode bit (word bit 0) is set by a permitted load with `ld_data[0]`=1. A load with `ld_data[0]`=0 never clears it. Only reset does.
- R5: Word bits 15..4 never change after reset, whatever a load carries.
- R6: A load never changes the task-switched bit (word bit 3).
- R7: A `task_sw` pulse sets the task-switched bit at the next edge.
- R8: A clear request with `real_mode`=1 or `cpl`=0 clears the task-switched bit at the next edge. Otherwise it raises `priv_fault` in that cycle and the bit is kept.
- R9: When `task_sw` and a permitted clear request fall in the same cycle, the task-switched bit ends up 1.
- R10: With `insn_valid`=1 and `insn_cls`=1 (escape), `nm_trap` is 1 whenever the emulate bit is 1.
- R11: With `insn_valid`=1 and `insn_cls`=1 (escape), `nm_trap` is 1 whenever the task-switched bit is 1.
- R12: With `insn_valid`=1 and `insn_cls`=2 (wait-type), `nm_trap` is 1 exactly when the monitor and task-switched bits are both 1. Class 0 (other), class 3 and `insn_valid`=0 never trap.
- R13: `trap_vec` shows 7 while `nm_trap` is 1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_cls | input | 2 | Class: 0 other, 1 escape, 2 wait-type, 3 other |
| ld_req | input | 1 | Load-word request |
| ld_data | input | 16 | Value offered by the load |
| clr_ts_req | input | 1 | Clear task-switched request |
| cpl | input | 2 | Current privilege level |
| real_mode | input | 1 | Processor is in real-address mode |
| task_sw | input | 1 | Hardware task-switch pulse |
| msw | output | 16 | Current machine status word |
| nm_trap | output | 1 | Coprocessor-not-present trap for this cycle |
| trap_vec | output | 8 | Trap vector, 7 when `nm_trap` is high |
| priv_fault | output | 1 | General protection fault for a disallowed load or clear |

## Verification
Two pairs of functions can land in the same cycle. A hardware task-switch pulse can meet a clear request, and an instruction can be checked for a trap while a load or clear is changing the bits it depends on. Directed steps drive `task_sw` and a permitted clear together and expect the flag to read 1 afterwards. They also present an escape or wait instruction in the same cycle as a load. The trap must follow the word as it stood before that edge, and the new value must be visible one cycle later. A random phase mixes all inputs every cycle, and a bench model predicts the trap, the fault and the next word.

// File: rtl/msw_cop_trap_pkg.sv
package msw_cop_trap_pkg;
   typedef enum logic [1:0] {
      CLS_OTHER = 2'd0,
      CLS_ESC   = 2'd1,
      CLS_WAIT  = 2'd2,
      CLS_RSVD  = 2'd3
   } insn_cls_e;

   localparam int BIT_PE = 0;
   localparam int BIT_MP = 1;
   localparam int BIT_EM = 2;
   localparam int BIT_TS = 3;
   localparam int LOW_W  = 4;

   typedef struct packed {
      logic ts;
      logic em;
      logic mp;
      logic pe;
   } msw_low_t;
endpackage

// File: rtl/msw_priv_gate.sv
module msw_priv_gate #(
   parameter int CPL_W = 2
) (
   input  logic             ld_req,
   input  logic             clr_ts_req,
   input  logic [CPL_W-1:0] cpl,
   input  logic             real_mode,
   output logic             ld_ok,
   output logic             clr_ok,
   output logic             priv_fault
);
   logic privileged;

   assign privileged = real_mode || (cpl == '0);
   assign ld_ok      = ld_req && privileged;
   assign clr_ok     = clr_ts_req && privileged;
   assign priv_fault = (ld_req || clr_ts_req) && !privileged;
endmodule

// File: rtl/msw_word_regs.sv
module msw_word_regs
   import msw_cop_trap_pkg::*;
#(
   parameter int          MSW_W     = 16,
   parameter int          RSVD_W    = MSW_W - LOW_W,
   parameter [RSVD_W-1:0] RSVD_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_ok,
   input  logic [LOW_W-1:0]  ld_low,
   input  logic              ts_set,
   input  logic              ts_clr,
   output msw_low_t          low_q,
   output logic [RSVD_W-1:0] rsvd_q
);
   msw_low_t low_d;

   always_comb begin
      low_d = low_q;
      if (ld_ok) begin
         low_d.pe = low_q.pe | ld_low[BIT_PE];
         low_d.mp = ld_low[BIT_MP];
         low_d.em = ld_low[BIT_EM];
      end
      if (ts_set)
         low_d.ts = 1'b1;
      else if (ts_clr)
         low_d.ts = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) low_q <= '0;
      else        low_q <= low_d;
   end

   for (genvar i = 0; i < RSVD_W; i++) begin : g_rsvd
      always_ff @(posedge clk) begin
         if (!rst_n) rsvd_q[i] <= RSVD_INIT[i];
         else        rsvd_q[i] <= rsvd_q[i];
      end
   end

   a_r4_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      low_q.pe |=> low_q.pe);
   a_r7_ts_set: assert property (@(posedge clk) disable iff (!rst_n)
      ts_set |=> low_q.ts);
   a_r6_ld_keeps_ts: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ok && !ts_set && !ts_clr) |=> (low_q.ts == $past(low_q.ts)));
endmodule

// File: rtl/msw_trap_decide.sv
module msw_trap_decide
   import msw_cop_trap_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int TRAP_VEC = 7
) (
   input  logic             insn_valid,
   input  logic [1:0]       insn_cls,
   input  msw_low_t         low_q,
   output logic             nm_trap,
   output logic [VEC_W-1:0] trap_vec
);
   logic esc_hit;
   logic wait_hit;

   assign esc_hit  = (insn_cls == CLS_ESC)  && (low_q.em || low_q.ts);
   assign wait_hit = (insn_cls == CLS_WAIT) && low_q.mp && low_q.ts;
   assign nm_trap  = insn_valid && (esc_hit || wait_hit);
   assign trap_vec = nm_trap ? VEC_W'(TRAP_VEC) : '0;
endmodule

// File: rtl/msw_cop_trap.sv
module msw_cop_trap
   import msw_cop_trap_pkg::*;
#(
   parameter int                  MSW_W     = 16,
   parameter int                  CPL_W     = 2,
   parameter int                  VEC_W     = 8,
   parameter int                  TRAP_VEC  = 7,
   parameter [MSW_W-LOW_W-1:0]    RSVD_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_valid,
   input  logic [1:0]       insn_cls,
   input  logic             ld_req,
   input  logic [MSW_W-1:0] ld_data,
   input  logic             clr_ts_req,
   input  logic [CPL_W-1:0] cpl,
   input  logic             real_mode,
   input  logic             task_sw,
   output logic [MSW_W-1:0] msw,
   output logic             nm_trap,
   output logic [VEC_W-1:0] trap_vec,
   output logic             priv_fault
);
   localparam int RSVD_W = MSW_W - LOW_W;

   if (MSW_W <= LOW_W) begin : g_chk_w
      $error("MSW_W must exceed the four defined bits");
   end
   if (TRAP_VEC >= (1 << VEC_W)) begin : g_chk_vec
      $error("TRAP_VEC does not fit in VEC_W");
   end

   logic              ld_ok;
   logic              clr_ok;
   msw_low_t          low_q;
   logic [RSVD_W-1:0] rsvd_q;
   logic              unused_rsvd_in;

   assign unused_rsvd_in = ^ld_data[MSW_W-1:LOW_W];

   msw_priv_gate #(.CPL_W(CPL_W)) u_gate (
      .ld_req(ld_req), .clr_ts_req(clr_ts_req), .cpl(cpl),
      .real_mode(real_mode), .ld_ok(ld_ok), .clr_ok(clr_ok),
      .priv_fault(priv_fault)
   );

   msw_word_regs #(.MSW_W(MSW_W), .RSVD_W(RSVD_W), .RSVD_INIT(RSVD_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .ld_ok(ld_ok), .ld_low(ld_data[LOW_W-1:0]),
      .ts_set(task_sw), .ts_clr(clr_ok), .low_q(low_q), .rsvd_q(rsvd_q)
   );

   msw_trap_decide #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_trap (
      .insn_valid(insn_valid), .insn_cls(insn_cls), .low_q(low_q),
      .nm_trap(nm_trap), .trap_vec(trap_vec)
   );

   assign msw = {rsvd_q, low_q.ts, low_q.em, low_q.mp, low_q.pe};

   a_r5_rsvd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(msw[MSW_W-1:LOW_W]));
   a_r3_denied_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && !real_mode && cpl != '0 && !task_sw && !clr_ts_req) |=> $stable(msw));
   a_r3_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && !real_mode && cpl != '0) |-> priv_fault);
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (task_sw && clr_ts_req) |=> msw[BIT_TS]);
   a_r12_wait_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_cls == CLS_WAIT && msw[BIT_MP] && msw[BIT_TS]) |-> nm_trap);
   a_r10_esc_em: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_cls == CLS_ESC && msw[BIT_EM]) |-> nm_trap);
   a_r13_vec: assert property (@(posedge clk) disable iff (!rst_n)
      nm_trap |-> (trap_vec == VEC_W'(TRAP_VEC)));
endmodule

// File: tb/msw_cop_trap_bench.sv
module msw_cop_trap_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        insn_valid = 0;
   logic [1:0]  insn_cls = 0;
   logic        ld_req = 0;
   logic [15:0] ld_data = 0;
   logic        clr_ts_req = 0;
   logic [1:0]  cpl = 0;
   logic        real_mode = 0;
   logic        task_sw = 0;
   logic [15:0] msw;
   logic        nm_trap;
   logic [7:0]  trap_vec;
   logic        priv_fault;

   int total = 0;
   int bad = 0;
   bit m_pe, m_mp, m_em, m_ts;

   msw_cop_trap u_msw_cop_trap (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_cls(insn_cls),
      .ld_req(ld_req), .ld_data(ld_data), .clr_ts_req(clr_ts_req), .cpl(cpl),
      .real_mode(real_mode), .task_sw(task_sw), .msw(msw), .nm_trap(nm_trap),
      .trap_vec(trap_vec), .priv_fault(priv_fault)
   );

   always #5 clk = ~clk;

   initial begin
      #1500000;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_priv();
      return real_mode || cpl == 2'd0;
   endfunction

   function automatic bit exp_trap();
      if (!insn_valid) return 0;
      if (insn_cls == 2'd1) return m_em || m_ts;
      if (insn_cls == 2'd2) return m_mp && m_ts;
      return 0;
   endfunction

   function automatic logic [15:0] exp_word();
      return {12'h000, m_ts, m_em, m_mp, m_pe};
   endfunction

   // Drive one cycle at the negedge, check combinational outputs, advance model.
   task automatic step(string tag, bit v, logic [1:0] c, bit ld, logic [15:0] d,
                       bit clr, logic [1:0] pl, bit rm, bit ts);
      insn_valid = v; insn_cls = c; ld_req = ld; ld_data = d;
      clr_ts_req = clr; cpl = pl; real_mode = rm; task_sw = ts;
      #1;
      chk({tag, " trap"}, {15'd0, nm_trap}, {15'd0, exp_trap()});
      chk({tag, " R13 vec"}, {8'd0, trap_vec}, exp_trap() ? 16'd7 : 16'd0);
      chk({tag, " fault"}, {15'd0, priv_fault}, {15'd0, (ld || clr) && !exp_priv()});
      if (ld && exp_priv()) begin
         m_pe = m_pe | d[0]; m_mp = d[1]; m_em = d[2];
      end
      if (ts) m_ts = 1;
      else if (clr && exp_priv()) m_ts = 0;
      @(posedge clk);
      @(negedge clk);
      insn_valid = 0; ld_req = 0; clr_ts_req = 0; task_sw = 0;
      chk({tag, " word"}, msw, exp_word());
   endtask

   initial begin
      process::self().srandom(32'h5eed_0007);
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 reset word", msw, 16'h0000);
      chk("R1 reset trap", {15'd0, nm_trap}, 16'd0);
      chk("R1 reset vec", {8'd0, trap_vec}, 16'd0);
      chk("R1 reset fault", {15'd0, priv_fault}, 16'd0);
      @(negedge clk);

      step("R12 wait no trap", 1, 2'd2, 0, 0, 0, 0, 0, 0);
      step("R3 denied load", 0, 0, 1, 16'h0007, 0, 2'd3, 0, 0);
      step("R2 R4 R5 load all", 0, 0, 1, 16'hFFF7, 0, 2'd0, 0, 0);
      chk("R5 reserved held", {4'd0, msw[15:4]}, 16'd0);
      step("R10 esc em", 1, 2'd1, 0, 0, 0, 0, 0, 0);
      step("R4 pe sticky", 0, 0, 1, 16'h0002, 0, 2'd1, 1, 0);
      chk("R4 pe still set", {15'd0, msw[0]}, 16'd1);
      step("R7 task switch", 0, 0, 0, 0, 0, 0, 0, 1);
      step("R12 wait trap", 1, 2'd2, 0, 0, 0, 0, 0, 0);
      step("R12 class3 no trap", 1, 2'd3, 0, 0, 0, 0, 0, 0);
      step("R6 load keeps ts", 0, 0, 1, 16'h0000, 0, 2'd0, 0, 0);
      chk("R6 ts kept", {15'd0, msw[3]}, 16'd1);
      step("R11 esc ts", 1, 2'd1, 0, 0, 0, 0, 0, 0);
      step("R8 denied clear", 0, 0, 0, 0, 1, 2'd2, 0, 0);
      step("R9 set wins", 0, 0, 0, 0, 1, 2'd0, 0, 1);
      chk("R9 ts one", {15'd0, msw[3]}, 16'd1);
      step("R8 clear", 1, 2'd1, 0, 0, 1, 2'd0, 0, 0);
      chk("R8 ts zero", {15'd0, msw[3]}, 16'd0);
      step("R2 load during esc", 1, 2'd1, 1, 16'h0004, 0, 2'd0, 0, 0);
      step("R10 em now set", 1, 2'd1, 0, 0, 0, 0, 0, 0);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] r = $urandom;
         step("R3 R12 random", r[0], r[2:1], r[3], $urandom, r[4] & r[5],
              r[7:6], r[8] & r[9], r[10] & r[11] & r[12]);
      end
      chk("R5 random reserved", {4'd0, msw[15:4]}, 16'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule